// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm Compare

The block is a register-mapped real-time clock. A prescaler counts input clock cycles and wraps at a parameterised terminal count. Each wrap produces a one-cycle seconds tick, and that tick advances a 29-bit seconds counter. A 29-bit alarm value is compared against the counter whenever the counter advances. A match sets a sticky alarm status bit, and an enable bit gates that status onto the interrupt output.

Software reaches six word registers over a simple request/write bus. A write takes one cycle. A read is a two-cycle access with a one-cycle valid strobe. When the seconds counter is read, bit 31 flags that a tick fell inside the access, so the value must be read again. The prescaler can only be loaded while the divider lock bit in the control register is clear. A load attempted while the lock is set changes nothing and raises a one-cycle error pulse.

Two resets are provided. The power-up/hardware reset clears everything. The other reset source clears everything except the alarm value.

The read side is a small state machine with three states:
- `BUS_IDLE`: accepts requests. A write is performed in place. A read moves to `BUS_CAPTURE` and latches the word index and any tick in that cycle.
- `BUS_CAPTURE`: always moves to `BUS_RESPOND`. It registers the addressed word, with the collision bit merged in for the seconds counter.
- `BUS_RESPOND`: drives the valid strobe and always returns to `BUS_IDLE`.

Requests that arrive outside `BUS_IDLE` are dropped.

Top module: `sec_rtc`

## Requirements
- R1: After the power-up reset (`por_n` low), the registers read as follows: control = 1 (divider lock set), interrupt enable = 0, alarm = 0, seconds count = 0, status = 0. `alarm_irq`, `ill_wr_err` and `rvalid` are 0. Word indices: 0 control (bit 0 lock), 1 interrupt enable (bit 0), 2 alarm, 3 seconds count, 4 prescaler, 5 status (bit 0 alarm flag); indices 6 and 7 read 0.
- R2: The prescaler increases by one on every clock. On the clock after it holds `DIV_TERM` it returns to 0, and the seconds count increases by one on that same edge. The count wraps from 2^29-1 to 0.
- R3: A read request accepted in `BUS_IDLE` gives `rvalid` high for exactly one cycle, two clocks after the request edge. `rdata` carries the register value as it stood before the second clock edge of the access.
- R4: A seconds-count read returns the count in bits 28:0 and zeros in bits 30:29. Bit 31 is 1 when a seconds tick happened on either clock edge of the access, and 0 otherwise.
- R5: While the lock bit is 0, a write to word 4 loads the prescaler with the written value.
- R6: While the lock bit is 1, a write to word 4 leaves the prescaler unchanged. `ill_wr_err` is high for the one cycle after that write.
- R7: A seconds tick that brings the count equal to the alarm sets the status flag. The flag stays set until a write to word 5 with bit 0 = 1 clears it.
- R8: Writing the seconds count to a value equal to the alarm does not set the status flag.
- R9: `alarm_irq` is high exactly when the status flag and the interrupt-enable bit are both 1.
- R10: The other reset (`soft_rst_n` low at a clock edge) clears control to 1, enable, count, prescaler and status. It leaves the alarm value unchanged. Only `por_n` clears the alarm.
- R11: The alarm register keeps only bits 28:0 of a write. Bits 31:29 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; also the prescaler count clock |
| por_n | input | 1 | Asynchronous power-up/hardware reset, active low |
| soft_rst_n | input | 1 | Synchronous other-source reset, active low; alarm kept |
| req | input | 1 | Bus request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | One-cycle read-data strobe |
| ill_wr_err | output | 1 | One-cycle pulse after a locked prescaler write |
| alarm_irq | output | 1 | Alarm interrupt, status flag gated by enable |

## Verification
The hardest case to reach from the ports is a seconds tick that lands exactly on the first or on the second clock edge of a count read, because the tick normally arrives only once every `DIV_TERM+1` cycles. To reach it, the bench clears the lock, loads the prescaler with `DIV_TERM-1` or `DIV_TERM` on the write just before the read, and then checks both the collision bit and which count value was captured. The alarm edge is reached the same way: the count is preloaded one below the alarm and the prescaler phase is fixed, so the first cycle in which `alarm_irq` may rise is known exactly.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_IEN   = 3'd1,
        REG_ALARM = 3'd2,
        REG_COUNT = 3'd3,
        REG_DIV   = 3'd4,
        REG_STAT  = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_CAPTURE,
        BUS_RESPOND
    } bus_state_e;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_TERM = 32767,
    parameter int DIV_W    = 15
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_clr,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic [DIV_W-1:0] div_q,
    output logic             tick
);

    localparam logic [DIV_W-1:0] TERM_V = DIV_W'(DIV_TERM);

    // Terminal count reached: the next edge wraps and advances the seconds.
    assign tick = (div_q == TERM_V);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            div_q <= '0;
        end else if (soft_clr) begin
            div_q <= '0;
        end else if (load) begin
            div_q <= load_val;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int SEC_W = 29
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_clr,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             alarm_wr,
    input  logic             clr_flag,
    input  logic [SEC_W-1:0] wval,
    output logic [SEC_W-1:0] cnt_q,
    output logic [SEC_W-1:0] alarm_q,
    output logic             flag_q
);

    logic [SEC_W-1:0] cnt_nxt;
    logic             hit;

    assign cnt_nxt = cnt_q + SEC_W'(1);
    // Compare only on a tick-driven advance, using the value about to load.
    assign hit     = tick && !cnt_wr && (cnt_nxt == alarm_q);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (soft_clr) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wval;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end

    // Alarm value survives the soft reset; only power-up clears it.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            alarm_q <= '0;
        end else if (alarm_wr) begin
            alarm_q <= wval;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (soft_clr) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= hit | (flag_q & ~clr_flag);
        end
    end

endmodule

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_clr,
    input  logic              req,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic              tick,
    input  logic [DATA_W-1:0] rd_word,
    output logic [2:0]        sel_q,
    output logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    bus_state_e state_q;
    bus_state_e state_nxt;
    logic       coll_q;
    logic       rd_start;

    assign rd_start = (state_q == BUS_IDLE) && req && !wr;
    assign wr_en    = (state_q == BUS_IDLE) && req && wr;
    assign rvalid   = (state_q == BUS_RESPOND);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= BUS_IDLE;
        end else if (soft_clr) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            BUS_IDLE:    if (rd_start) state_nxt = BUS_CAPTURE;
            BUS_CAPTURE: state_nxt = BUS_RESPOND;
            BUS_RESPOND: state_nxt = BUS_IDLE;
            default:     state_nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sel_q  <= '0;
            coll_q <= 1'b0;
            rdata  <= '0;
        end else if (soft_clr) begin
            sel_q  <= '0;
            coll_q <= 1'b0;
            rdata  <= '0;
        end else begin
            if (rd_start) begin
                sel_q  <= addr;
                coll_q <= tick;
            end
            if (state_q == BUS_CAPTURE) begin
                rdata <= rd_word;
                if (sel_q == REG_COUNT) begin
                    rdata[DATA_W-1] <= coll_q | tick;
                end
            end
        end
    end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import rtc_pkg::*;
#(
    parameter int DIV_TERM = 32767,
    parameter int SEC_W    = 29
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        soft_rst_n,
    input  logic        req,
    input  logic        wr,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        rvalid,
    output logic        ill_wr_err,
    output logic        alarm_irq
);

    localparam int DIV_W = (DIV_TERM < 2) ? 1 : $clog2(DIV_TERM + 1);

    logic              soft_clr;
    logic              wr_en;
    logic [2:0]        sel_q;
    logic [DATA_W-1:0] rd_word;
    logic              lock_q;
    logic              ien_q;
    logic              err_q;
    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic [SEC_W-1:0]  cnt_q;
    logic [SEC_W-1:0]  alarm_q;
    logic              flag_q;
    logic              div_wr;
    logic              div_bad;
    logic              unused_wd;

    assign soft_clr  = !soft_rst_n;
    assign div_wr    = wr_en && (addr == REG_DIV) && !lock_q;
    assign div_bad   = wr_en && (addr == REG_DIV) && lock_q;
    assign unused_wd = ^wdata;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock_q <= 1'b1;
            ien_q  <= 1'b0;
            err_q  <= 1'b0;
        end else if (soft_clr) begin
            lock_q <= 1'b1;
            ien_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= div_bad;
            if (wr_en && addr == REG_CTRL) lock_q <= wdata[0];
            if (wr_en && addr == REG_IEN)  ien_q  <= wdata[0];
        end
    end

    always_comb begin
        rd_word = '0;
        case (sel_q)
            REG_CTRL:  rd_word[0]         = lock_q;
            REG_IEN:   rd_word[0]         = ien_q;
            REG_ALARM: rd_word[SEC_W-1:0] = alarm_q;
            REG_COUNT: rd_word[SEC_W-1:0] = cnt_q;
            REG_DIV:   rd_word[DIV_W-1:0] = div_q;
            REG_STAT:  rd_word[0]         = flag_q;
            default:   rd_word            = '0;
        endcase
    end

    rtc_prescaler #(
        .DIV_TERM (DIV_TERM),
        .DIV_W    (DIV_W)
    ) u_presc (
        .clk      (clk),
        .por_n    (por_n),
        .soft_clr (soft_clr),
        .load     (div_wr),
        .load_val (wdata[DIV_W-1:0]),
        .div_q    (div_q),
        .tick     (tick)
    );

    rtc_sec_counter #(
        .SEC_W (SEC_W)
    ) u_secs (
        .clk      (clk),
        .por_n    (por_n),
        .soft_clr (soft_clr),
        .tick     (tick),
        .cnt_wr   (wr_en && addr == REG_COUNT),
        .alarm_wr (wr_en && addr == REG_ALARM),
        .clr_flag (wr_en && addr == REG_STAT && wdata[0]),
        .wval     (wdata[SEC_W-1:0]),
        .cnt_q    (cnt_q),
        .alarm_q  (alarm_q),
        .flag_q   (flag_q)
    );

    rtc_bus_fsm u_bus (
        .clk      (clk),
        .por_n    (por_n),
        .soft_clr (soft_clr),
        .req      (req),
        .wr       (wr),
        .addr     (addr),
        .tick     (tick),
        .rd_word  (rd_word),
        .sel_q    (sel_q),
        .wr_en    (wr_en),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    assign ill_wr_err = err_q;
    assign alarm_irq  = flag_q & ien_q;

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
    import rtc_pkg::*;
#(
    parameter int SEC_W = 29
) (
    input logic             clk,
    input logic             por_n,
    input logic             soft_rst_n,
    input logic [2:0]       addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic             rvalid,
    input logic             ill_wr_err,
    input logic             wr_en,
    input logic             flag_q,
    input logic [SEC_W-1:0] alarm_q
);

    // R6
    err_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        ill_wr_err |-> $past(wr_en && addr == REG_DIV));

    // R3
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        rvalid |=> !rvalid);

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        rvalid |-> (rdata[30:29] == 2'b00));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (flag_q && soft_rst_n && !(wr_en && addr == REG_STAT && wdata[0])) |=> flag_q);

    // R10
    alarm_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_en && addr == REG_ALARM) |=> $stable(alarm_q));

endmodule

bind sec_rtc sec_rtc_chk #(.SEC_W(SEC_W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .soft_rst_n (soft_rst_n),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .ill_wr_err (ill_wr_err),
    .wr_en      (wr_en),
    .flag_q     (flag_q),
    .alarm_q    (alarm_q)
);

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;

    localparam int CLK_PERIOD = 10;
    localparam int TERM       = 9;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_IEN   = 3'd1;
    localparam logic [2:0] A_ALARM = 3'd2;
    localparam logic [2:0] A_COUNT = 3'd3;
    localparam logic [2:0] A_DIV   = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        ill_wr_err;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sec_rtc #(.DIV_TERM(TERM), .SEC_W(29)) u0 (
        .clk        (clk),
        .por_n      (por_n),
        .soft_rst_n (soft_rst_n),
        .req        (req),
        .wr         (wr),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rvalid     (rvalid),
        .ill_wr_err (ill_wr_err),
        .alarm_irq  (alarm_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        req = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check("R3 rvalid", {31'b0, rvalid}, 32'd1);
        d = rdata;
        @(negedge clk);
        check("R3 rvalid drop", {31'b0, rvalid}, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, alarm_irq}, 0);
        check("R1 err", {31'b0, ill_wr_err}, 0);
        check("R1 rvalid", {31'b0, rvalid}, 0);
        rd_reg(A_COUNT, d); check("R1 count", d, 0);
        rd_reg(A_CTRL, d);  check("R1 ctrl", d, 1);
        rd_reg(A_IEN, d);   check("R1 ien", d, 0);
        rd_reg(A_ALARM, d); check("R1 alarm", d, 0);
        rd_reg(A_STAT, d);  check("R1 stat", d, 0);
        rd_reg(3'd7, d);    check("R1 unused word", d, 0);
    endtask

    task automatic t_div_unlocked();
        logic [31:0] d;
        wr_reg(A_CTRL, 0);
        wr_reg(A_DIV, 3);
        rd_reg(A_DIV, d); check("R5 div load", d, 4);
    endtask

    task automatic t_div_locked();
        logic [31:0] d;
        wr_reg(A_DIV, 2);
        wr_reg(A_CTRL, 1);
        wr_reg(A_DIV, 0);
        check("R6 err pulse", {31'b0, ill_wr_err}, 1);
        rd_reg(A_DIV, d); check("R6 div unchanged", d, 5);
        check("R6 err single", {31'b0, ill_wr_err}, 0);
        rd_reg(A_CTRL, d); check("R6 lock readback", d, 1);
    endtask

    task automatic t_seconds();
        logic [31:0] d;
        wr_reg(A_CTRL, 0);
        wr_reg(A_DIV, 0);
        wr_reg(A_COUNT, 50);
        rd_reg(A_COUNT, d); check("R2 count stable", d, 50);
        idle(10);
        rd_reg(A_COUNT, d); check("R2 count advance", d, 51);
        rd_reg(A_DIV, d);   check("R2 div value", d, 8);
        rd_reg(A_DIV, d);   check("R2 div wrap", d, 1);
        wr_reg(A_DIV, 0);
        wr_reg(A_COUNT, 32'h1FFF_FFFF);
        idle(10);
        rd_reg(A_COUNT, d); check("R2 count wrap", d, 0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        wr_reg(A_DIV, 0);
        wr_reg(A_COUNT, 200);
        wr_reg(A_DIV, TERM - 1);
        rd_reg(A_COUNT, d); check("R4 tick on second edge", d, 32'h8000_0000 | 32'd200);
        wr_reg(A_DIV, 0);
        wr_reg(A_COUNT, 300);
        wr_reg(A_DIV, TERM);
        rd_reg(A_COUNT, d); check("R4 tick on first edge", d, 32'h8000_0000 | 32'd301);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr_reg(A_ALARM, 32'hFFFF_FFFF);
        rd_reg(A_ALARM, d); check("R11 alarm bits", d, 32'h1FFF_FFFF);
        wr_reg(A_DIV, 0);
        wr_reg(A_COUNT, 32'hFFFF_FFFF);
        rd_reg(A_COUNT, d); check("R4 count rsvd", d, 32'h1FFF_FFFF);
    endtask

    task automatic t_alarm();
        logic [31:0] d;
        wr_reg(A_STAT, 1);
        rd_reg(A_STAT, d); check("R7 cleared before", d, 0);
        wr_reg(A_ALARM, 400);
        wr_reg(A_IEN, 1);
        wr_reg(A_DIV, 0);
        wr_reg(A_COUNT, 399);
        idle(7);
        check("R7 irq early", {31'b0, alarm_irq}, 0);
        idle(1);
        check("R7 irq before tick", {31'b0, alarm_irq}, 0);
        idle(1);
        check("R7 irq at match", {31'b0, alarm_irq}, 1);
        idle(20);
        check("R7 irq sticky", {31'b0, alarm_irq}, 1);
        rd_reg(A_STAT, d); check("R7 stat set", d, 1);
        wr_reg(A_IEN, 0);
        check("R9 masked", {31'b0, alarm_irq}, 0);
        rd_reg(A_STAT, d); check("R9 flag kept", d, 1);
        wr_reg(A_IEN, 1);
        check("R9 unmasked", {31'b0, alarm_irq}, 1);
        wr_reg(A_STAT, 1);
        check("R7 w1c irq", {31'b0, alarm_irq}, 0);
        rd_reg(A_STAT, d); check("R7 w1c stat", d, 0);
    endtask

    task automatic t_write_match();
        logic [31:0] d;
        wr_reg(A_DIV, 0);
        wr_reg(A_COUNT, 400);
        rd_reg(A_STAT, d); check("R8 no flag", d, 0);
        check("R8 no irq", {31'b0, alarm_irq}, 0);
    endtask

    task automatic t_resets();
        logic [31:0] d;
        soft_rst_n = 1'b0;
        @(negedge clk);
        soft_rst_n = 1'b1;
        rd_reg(A_COUNT, d); check("R10 count cleared", d, 0);
        rd_reg(A_ALARM, d); check("R10 alarm kept", d, 400);
        rd_reg(A_IEN, d);   check("R10 ien cleared", d, 0);
        rd_reg(A_CTRL, d);  check("R10 lock set", d, 1);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        rd_reg(A_ALARM, d); check("R10 por alarm", d, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        t_reset();
        t_div_unlocked();
        t_div_locked();
        t_seconds();
        t_collision();
        t_reserved();
        t_alarm();
        t_write_match();
        t_resets();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule